// File: doc/BRIEF.md
# Divider Configuration Load Interface

This block is the digital control port of a PLL frequency synthesizer. It loads a 9-bit feedback divider value and a 2-bit output divider code, and it offers two ways to do so. The parallel path is transparent while its active-low strobe is low. It freezes the parallel inputs on the strobe's rising edge. The serial path shifts a 14-bit frame in on a serial clock, and a rising edge of the serial-load strobe commits that frame to the outputs. A serial commit overrides anything the parallel path latched before it.

Every external pin is sampled in a single system-clock domain through a two-flop synchronizer. An edge detector follows the synchronizer, so each pin edge acts exactly once. The committed values drive the divider counters downstream. The block also reports the decoded output divide ratio. It raises a flag when the feedback value lies outside the range the VCO supports. A committed test code of 001 turns the feedback register into a shift chain that takes serial data directly.

Top module: `divcfg_load`

## Requirements
- R1: While `rst` is high, `m_out` is 0x1FF, `n_out` is 2'b11, `test_out` is 3'b000, `div_ratio` is 1 and `out_of_range` is 1.
- R2: While `pload_n` is low and `sload` is low, `m_out` and `n_out` follow `m_in` and `n_in` with a delay of three clock cycles, and `test_out` is 3'b000.
- R3: A rising edge on `pload_n` latches `m_in` and `n_in`. Later changes on those inputs have no effect while `pload_n` stays high.
- R4: While `pload_n` is high and `sload` is low, each rising edge of `sclk` shifts `sdata` into a 14-bit register, most significant bit first. The frame order is test[2:0], then N[1:0], then M[8:0], so the last bit shifted is M0.
- R5: A rising edge on `sload` copies the frame to `test_out`, `n_out` and `m_out`. This overrides any value latched by the parallel path.
- R6: While `sload` stays high and `test_out` is not 3'b001, changes on the parallel inputs, `pload_n`, `sclk` and `sdata` leave `m_out`, `n_out` and `test_out` unchanged.
- R7: `div_ratio` decodes `n_out` as follows: 2'b00 gives 2, 2'b01 gives 4, 2'b10 gives 8 and 2'b11 gives 1.
- R8: `m_out` carries any committed value as written. `out_of_range` is 1 exactly when `m_out` is below 125 or above 360.
- R9: While `sload` is high and `test_out` is 3'b001, each rising edge of `sclk` shifts `sdata` into `m_out` at bit 0 and drops bit 8.
- R10: A pin edge takes effect three clock cycles after it appears. A level held for many cycles acts only once, so an `sclk` pulse of any length shifts exactly one bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pload_n | input | 1 | Parallel-load strobe, active low |
| sload | input | 1 | Serial-load commit strobe |
| sclk | input | 1 | Serial shift clock pin |
| sdata | input | 1 | Serial data pin |
| m_in | input | 9 | Parallel feedback divider value |
| n_in | input | 2 | Parallel output divider code |
| m_out | output | 9 | Applied feedback divider value |
| n_out | output | 2 | Applied output divider code |
| test_out | output | 3 | Applied test code |
| div_ratio | output | 4 | Decoded output divide ratio |
| out_of_range | output | 1 | Feedback value lies outside 125..360 |

## Verification
A pin value driven between two clock edges reaches `m_out`, `n_out` and `test_out` after the third rising edge that follows it. `div_ratio` and `out_of_range` settle within that same cycle. The bench keeps a queue of the pin values it sampled and applies the load rules to the entry that is two edges old. It compares all five outputs with this model on every falling edge. The directed checks wait at least three cycles after their last stimulus, and a strobe or serial clock is held for at least two cycles so that each edge crosses the synchronizer.

// File: rtl/divcfg_load.sv
module divcfg_load #(
  parameter int MW = 9,
  parameter int NW = 2,
  parameter int TW = 3,
  parameter int RW = 4,
  parameter int M_MIN = 125,
  parameter int M_MAX = 360,
  parameter logic [TW-1:0] TEST_SHIFT = 3'b001
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pload_n,
  input  logic          sload,
  input  logic          sclk,
  input  logic          sdata,
  input  logic [MW-1:0] m_in,
  input  logic [NW-1:0] n_in,
  output logic [MW-1:0] m_out,
  output logic [NW-1:0] n_out,
  output logic [TW-1:0] test_out,
  output logic [RW-1:0] div_ratio,
  output logic          out_of_range
);
  localparam int FW = TW + NW + MW;

  logic [1:0]    pl_sy, sl_sy, sc_sy, sd_sy;
  logic [MW-1:0] m_sy1, m_sy2;
  logic [NW-1:0] n_sy1, n_sy2;
  logic          pl_d, sl_d, sc_d;
  logic [FW-1:0] shift_q;
  logic [MW-1:0] m_q;
  logic [NW-1:0] n_q;
  logic [TW-1:0] t_q;

  logic pl_s, sl_s, sc_s, sd_s;
  logic pl_rise, sl_rise, sc_rise;

  assign pl_s    = pl_sy[1];
  assign sl_s    = sl_sy[1];
  assign sc_s    = sc_sy[1];
  assign sd_s    = sd_sy[1];
  assign pl_rise = pl_s & ~pl_d;
  assign sl_rise = sl_s & ~sl_d;
  assign sc_rise = sc_s & ~sc_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      pl_sy   <= 2'b11;
      sl_sy   <= '0;
      sc_sy   <= '0;
      sd_sy   <= '0;
      m_sy1   <= '0;
      m_sy2   <= '0;
      n_sy1   <= '0;
      n_sy2   <= '0;
      pl_d    <= 1'b1;
      sl_d    <= 1'b0;
      sc_d    <= 1'b0;
      shift_q <= '0;
      m_q     <= '1;
      n_q     <= '1;
      t_q     <= '0;
    end else begin
      pl_sy <= {pl_sy[0], pload_n};
      sl_sy <= {sl_sy[0], sload};
      sc_sy <= {sc_sy[0], sclk};
      sd_sy <= {sd_sy[0], sdata};
      m_sy1 <= m_in;
      m_sy2 <= m_sy1;
      n_sy1 <= n_in;
      n_sy2 <= n_sy1;
      pl_d  <= pl_s;
      sl_d  <= sl_s;
      sc_d  <= sc_s;

      if (sc_rise && pl_s && !sl_s)
        shift_q <= {shift_q[FW-2:0], sd_s};

      if (sl_rise) begin
        {t_q, n_q, m_q} <= shift_q;
      end else if (sl_s) begin
        if (t_q == TEST_SHIFT && sc_rise)
          m_q <= {m_q[MW-2:0], sd_s};
      end else if (!pl_s || pl_rise) begin
        m_q <= m_sy2;
        n_q <= n_sy2;
        t_q <= '0;
      end
    end
  end

  assign m_out        = m_q;
  assign n_out        = n_q;
  assign test_out     = t_q;
  assign div_ratio    = (&n_q) ? RW'(1) : (RW'(2) << n_q);
  assign out_of_range = (int'(m_q) < M_MIN) || (int'(m_q) > M_MAX);
endmodule

// File: rtl/divcfg_load_chk.sv
module divcfg_load_chk #(
  parameter int MW = 9,
  parameter int NW = 2,
  parameter int TW = 3,
  parameter int RW = 4,
  parameter int FW = 14,
  parameter int M_MIN = 125,
  parameter int M_MAX = 360,
  parameter logic [TW-1:0] TEST_SHIFT = 3'b001
) (
  input logic          clk,
  input logic          rst,
  input logic [MW-1:0] m_out,
  input logic [NW-1:0] n_out,
  input logic [TW-1:0] test_out,
  input logic [RW-1:0] div_ratio,
  input logic          out_of_range,
  input logic          pl_s,
  input logic          sl_s,
  input logic          sl_d,
  input logic          sc_rise,
  input logic [FW-1:0] shift_q
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (m_out == '1 && n_out == '1 && test_out == '0));

  a_r2_test_cleared: assert property (@(posedge clk) disable iff (rst)
    (!pl_s && !sl_s) |=> test_out == '0);

  a_r4_shift_on_edge_only: assert property (@(posedge clk) disable iff (rst)
    !sc_rise |=> $stable(shift_q));

  a_r6_hold_while_high: assert property (@(posedge clk) disable iff (rst)
    (sl_s && sl_d && test_out != TEST_SHIFT) |=> ($stable(m_out) && $stable(n_out) && $stable(test_out)));

  a_r7_ratio_decode: assert property (@(posedge clk) disable iff (rst)
    $onehot(div_ratio) && ((n_out == '1) == (div_ratio == RW'(1))));

  a_r8_flag_in_range: assert property (@(posedge clk) disable iff (rst)
    !out_of_range |-> (int'(m_out) >= M_MIN && int'(m_out) <= M_MAX));

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    sc_rise |=> !sc_rise);
endmodule

bind divcfg_load divcfg_load_chk #(
  .MW(MW), .NW(NW), .TW(TW), .RW(RW), .FW(FW),
  .M_MIN(M_MIN), .M_MAX(M_MAX), .TEST_SHIFT(TEST_SHIFT)
) u_chk (
  .clk(clk), .rst(rst), .m_out(m_out), .n_out(n_out), .test_out(test_out),
  .div_ratio(div_ratio), .out_of_range(out_of_range), .pl_s(pl_s),
  .sl_s(sl_s), .sl_d(sl_d), .sc_rise(sc_rise), .shift_q(shift_q)
);

// File: tb/test_divcfg_load.sv
`timescale 1ns/1ps
module test_divcfg_load;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pload_n = 1'b1, sload = 1'b0, sclk = 1'b0, sdata = 1'b0;
  logic [8:0] m_in = '0;
  logic [1:0] n_in = '0;
  logic [8:0] m_out;
  logic [1:0] n_out;
  logic [2:0] test_out;
  logic [3:0] div_ratio;
  logic       out_of_range;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  divcfg_load i_divcfg_load (
    .clk(clk), .rst(rst), .pload_n(pload_n), .sload(sload), .sclk(sclk),
    .sdata(sdata), .m_in(m_in), .n_in(n_in), .m_out(m_out), .n_out(n_out),
    .test_out(test_out), .div_ratio(div_ratio), .out_of_range(out_of_range)
  );

  // Behavioural reference: pin history queue, newest at front.
  logic [14:0] hq[$] = '{15'h4000, 15'h4000, 15'h4000};
  int mm = 511, mn = 3, mt = 0, msr = 0;

  always @(posedge clk) begin
    logic [14:0] cur, prv;
    int nsr;
    bit scr;
    cur = hq[1];
    prv = hq[2];
    if (rst) begin
      mm = 511; mn = 3; mt = 0; msr = 0;
    end else begin
      scr = cur[12] && !prv[12];
      nsr = msr;
      if (scr && cur[14] && !cur[13]) nsr = ((msr << 1) | int'(cur[11])) & 16'h3FFF;
      if (cur[13] && !prv[13]) begin
        mt = msr >> 11; mn = (msr >> 9) & 3; mm = msr & 511;
      end else if (cur[13]) begin
        if (mt == 1 && scr) mm = ((mm << 1) | int'(cur[11])) & 511;
      end else if (!cur[14] || !prv[14]) begin
        mm = int'(cur[10:2]); mn = int'(cur[1:0]); mt = 0;
      end
      msr = nsr;
    end
    hq.push_front({pload_n, sload, sclk, sdata, m_in, n_in});
    void'(hq.pop_back());
  end

  function automatic int ratio_of(int n);
    case (n)
      0: return 2;
      1: return 4;
      2: return 8;
      default: return 1;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk(int'(m_out) == mm, "R2/R3/R5/R6/R9 model m_out", int'(m_out), mm);
    chk(int'(n_out) == mn, "R2/R3/R5/R6 model n_out", int'(n_out), mn);
    chk(int'(test_out) == mt, "R2/R5 model test_out", int'(test_out), mt);
    chk(int'(div_ratio) == ratio_of(mn), "R7 model div_ratio", int'(div_ratio), ratio_of(mn));
    chk(out_of_range == (mm < 125 || mm > 360), "R8 model out_of_range",
        int'(out_of_range), int'(mm < 125 || mm > 360));
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(logic [13:0] fr, int hold);
    for (int i = 13; i >= 0; i--) begin
      sdata = fr[i];
      step(2);
      sclk = 1'b1;
      step(hold);
      sclk = 1'b0;
      step(2);
    end
  endtask

  task automatic show(int mexp, int nexp, int texp, string tag);
    chk(int'(m_out) == mexp, {tag, " m_out"}, int'(m_out), mexp);
    chk(int'(n_out) == nexp, {tag, " n_out"}, int'(n_out), nexp);
    chk(int'(test_out) == texp, {tag, " test_out"}, int'(test_out), texp);
  endtask

  initial begin
    step(5);
    // R1 reset state
    show(511, 3, 0, "R1");
    chk(div_ratio == 4'd1, "R1 div_ratio", int'(div_ratio), 1);
    chk(out_of_range == 1'b1, "R1 out_of_range", int'(out_of_range), 1);
    rst = 1'b0;
    step(4);

    // R2 transparent parallel path, three-cycle delay
    pload_n = 1'b0; m_in = 9'd200; n_in = 2'd1;
    step(2);
    chk(int'(m_out) == 511, "R10 not yet at two cycles", int'(m_out), 511);
    step(1);
    show(200, 1, 0, "R2");
    chk(div_ratio == 4'd4, "R7 code 01", int'(div_ratio), 4);
    m_in = 9'd300; n_in = 2'd2;
    step(3);
    show(300, 2, 0, "R2");
    chk(div_ratio == 4'd8, "R7 code 10", int'(div_ratio), 8);

    // R3 latch on rising parallel strobe
    pload_n = 1'b1;
    step(2);
    m_in = 9'd130; n_in = 2'd0;
    step(6);
    show(300, 2, 0, "R3");

    // R4/R5 serial frame with long sclk pulses (R10), overriding the latch
    send_frame({3'b000, 2'b11, 9'd250}, 9);
    sload = 1'b1;
    step(4);
    show(250, 3, 0, "R5");
    chk(div_ratio == 4'd1, "R7 code 11", int'(div_ratio), 1);

    // R6 everything ignored while sload stays high
    m_in = 9'd140; n_in = 2'd0; pload_n = 1'b0;
    step(3);
    pload_n = 1'b1;
    step(3);
    sdata = 1'b1; sclk = 1'b1; step(3); sclk = 1'b0; step(3);
    show(250, 3, 0, "R6");
    pload_n = 1'b0; sload = 1'b0;
    step(4);
    show(140, 0, 0, "R2");
    chk(div_ratio == 4'd2, "R7 code 00", int'(div_ratio), 2);

    // R8 range boundaries through the parallel path
    m_in = 9'd124; step(3);
    chk(out_of_range == 1'b1, "R8 value 124", int'(out_of_range), 1);
    chk(m_out == 9'd124, "R8 value applied", int'(m_out), 124);
    m_in = 9'd125; step(3);
    chk(out_of_range == 1'b0, "R8 value 125", int'(out_of_range), 0);
    m_in = 9'd360; step(3);
    chk(out_of_range == 1'b0, "R8 value 360", int'(out_of_range), 0);
    m_in = 9'd361; step(3);
    chk(out_of_range == 1'b1, "R8 value 361", int'(out_of_range), 1);
    pload_n = 1'b1;
    step(3);

    // R4 out-of-range serial commit still applied (R8)
    send_frame({3'b000, 2'b00, 9'd100}, 2);
    sload = 1'b1; step(4);
    show(100, 0, 0, "R4");
    chk(out_of_range == 1'b1, "R8 serial 100", int'(out_of_range), 1);
    sload = 1'b0; step(3);

    // R9 test code 001: serial data shifts straight into m_out
    send_frame({3'b001, 2'b10, 9'd5}, 2);
    sload = 1'b1; step(4);
    show(5, 2, 1, "R9 commit");
    for (int b = 0; b < 3; b++) begin
      sdata = (b != 1);
      step(2);
      sclk = 1'b1; step(2);
      sclk = 1'b0; step(2);
    end
    step(2);
    show(45, 2, 1, "R9");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    done = 1'b1;
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule